// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block samples up to eight asynchronous interrupt pins, detects on each one the event selected by that pin's sense code (falling edge, rising edge, low level, high level or either edge), and latches detected events into a pending register. Each pin has a mask bit, a four-bit priority field and a pending bit. A pin's output is raised while its request is pending, the pin is unmasked, its priority field is nonzero and, when the build includes it, the per-pin mode bit in the control register is set. An OR of all pin outputs serves a system in which every pin shares one parent line.

Software reaches the block through a synchronous register port: address, write enable, write data, read enable and registered read data. Pin bits in the pending, mask-set and mask-clear registers are numbered from the most significant bit down. Pending bits are cleared by writing zero to them, so a write of the inverted one-hot mask clears one pin alone. Masking and unmasking use two separate write-only registers, so no read-modify-write is needed.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset every pin is masked, every priority field and the sense register are 0, nothing is pending, the mode bit is 0 and `irq_o` and `irq_any_o` are low.
- R2: Each pin passes through a two-flop synchronizer. A pin change made before rising clock edge k sets the pending bit at edge k+2, so the output can rise after edge k+2 and is still low after edge k+1.
- R3: Pin n's sense code sits in the sense register (address 0) at bits [31-n*W -: W], W being `SENSE_W` (2 or 4). Code 0 detects a falling edge, 1 a rising edge, 2 a low level, 3 a high level and 4 either edge (only when W is 4). Any other code detects nothing.
- R4: In the level modes the pending bit is set again on every clock while the level is active, so a clear has no effect until the pin returns inactive. In the edge modes the bit stays set after the pin settles, until software clears it.
- R5: The pending register (address 2) holds pin n at bit `SRC_W`-1-n. A write clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R6: A write to the mask-set register (address 3) masks every pin whose bit (same bit mapping as R5) is 1. Bits written as 0 change nothing. A masked pin's output stays low.
- R7: A write to the mask-clear register (address 4) unmasks every pin whose bit (same mapping) is 1. Bits written as 0 change nothing.
- R8: The priority register (address 1) holds a 4-bit field for pin n at bits [31-4n -: 4]. A field of 0 holds that pin's output low, and any nonzero value lets it through.
- R9: With `HAS_MODE` set, control register bit 23 (address 5) must be 1 for any pin output to rise. With `HAS_MODE` clear, the outputs are not gated by it.
- R10: `irq_any_o` is high exactly when at least one bit of `irq_o` is high.
- R11: A read is registered. `rdata_o` shows, one clock after `re_i`, the sense, priority or control register as written, or the pending bits at their mapped positions with all other bits 0. Addresses 3 and 4 read as 0, and `rdata_o` is 0 after a clock without `re_i`.
- R12: When a pin event is detected in the same clock as a write that clears that pin's pending bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, index n is pin n |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_PINS | Per-pin interrupt request, index n is pin n |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
Register writes take effect at the clock edge that samples them, and the outputs follow combinationally, so an output after a write is checked at the next falling edge. A pin change passes two synchronizer flops and then the pending flop, so the bench checks after two falling edges that nothing has appeared yet and after the third that the request is present. Read data is registered and is taken at the falling edge after the sampling edge. The same-cycle race of R12 is set up by timing the clearing write to land on the third edge after the pin rises.

// File: rtl/extpin_pkg.sv
package extpin_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int PRIO_W   = 4;
    localparam int MODE_BIT = 23;

    localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRIO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

    typedef enum logic [3:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;
endpackage

// File: rtl/extpin_pin_detect.sv
module extpin_pin_detect
    import extpin_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic               hit_o
);
    logic   sync1_q, sync2_q, prev_q;
    sense_e code;

    // two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        code  = sense_e'(4'(sense_i));
        hit_o = 1'b0;
        unique case (code)
            SNS_FALL: hit_o = prev_q & ~sync2_q;
            SNS_RISE: hit_o = ~prev_q & sync2_q;
            SNS_LOW:  hit_o = ~sync2_q;
            SNS_HIGH: hit_o = sync2_q;
            SNS_BOTH: hit_o = prev_q ^ sync2_q;
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/extpin_regs.sv
module extpin_regs
    import extpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SRC_W    = 8,
    parameter int HAS_MODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [DATA_W-1:0] sense_q,
    output logic [DATA_W-1:0] prio_q,
    output logic [NUM_PINS-1:0] pend_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic              mode_q
);
    logic [NUM_PINS-1:0] keep, mset, mclr;
    logic [DATA_W-1:0]   pend_view, rd_val;

    // per-pin decode of the MSB-first bit position
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
        localparam int SB = SRC_W - 1 - n;
        assign keep[n] = !(we_i && addr_i == A_PEND) || wdata_i[SB];
        assign mset[n] = we_i && addr_i == A_MSET && wdata_i[SB];
        assign mclr[n] = we_i && addr_i == A_MCLR && wdata_i[SB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
        end else begin
            if (we_i && addr_i == A_SENSE) sense_q <= wdata_i;
            if (we_i && addr_i == A_PRIO)  prio_q  <= wdata_i;
            // a fresh detection wins over a same-cycle clear
            pend_q <= (pend_q & keep) | hit_i;
            mask_q <= (mask_q | mset) & ~mclr;
        end
    end

    if (HAS_MODE != 0) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mode_q <= 1'b0;
            else if (we_i && addr_i == A_CTRL) mode_q <= wdata_i[MODE_BIT];
        end
    end else begin : g_nomode
        assign mode_q = 1'b0;
    end

    always_comb begin
        pend_view = '0;
        for (int n = 0; n < NUM_PINS; n++) pend_view[SRC_W-1-n] = pend_q[n];
    end

    always_comb begin
        rd_val = '0;
        unique case (addr_i)
            A_SENSE: rd_val = sense_q;
            A_PRIO:  rd_val = prio_q;
            A_PEND:  rd_val = pend_view;
            A_CTRL:  rd_val[MODE_BIT] = mode_q;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= re_i ? rd_val : '0;
    end
endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl
    import extpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8,
    parameter int HAS_MODE = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                re_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);
    logic [DATA_W-1:0]   sense_q, prio_q;
    logic [NUM_PINS-1:0] pend_q, mask_q, hit;
    logic                mode_q, mode_ok;

    extpin_regs #(
        .NUM_PINS(NUM_PINS), .SRC_W(SRC_W), .HAS_MODE(HAS_MODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
        .re_i(re_i), .rdata_o(rdata_o),
        .hit_i(hit),
        .sense_q(sense_q), .prio_q(prio_q),
        .pend_q(pend_q), .mask_q(mask_q), .mode_q(mode_q)
    );

    assign mode_ok = (HAS_MODE != 0) ? mode_q : 1'b1;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int SSH = DATA_W - (n + 1) * SENSE_W;
        localparam int PSH = DATA_W - (n + 1) * PRIO_W;

        extpin_pin_detect #(.SENSE_W(SENSE_W)) u_det (
            .clk(clk), .rst_n(rst_n),
            .pin_i(pin_i[n]),
            .sense_i(sense_q[SSH +: SENSE_W]),
            .hit_o(hit[n])
        );

        assign irq_o[n] = pend_q[n] & ~mask_q[n] & (|prio_q[PSH +: PRIO_W]) & mode_ok;
    end

    assign irq_any_o = |irq_o;
endmodule

// File: rtl/extpin_irq_ctrl_chk.sv
module extpin_irq_ctrl_chk
    import extpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SRC_W    = 8,
    parameter int HAS_MODE = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [SRC_W-1:0]    wdata_i,
    input logic [NUM_PINS-1:0] irq_o,
    input logic [NUM_PINS-1:0] pend_q,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [PRIO_W-1:0]   prio0,
    input logic                mode_q
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_q == '0 && mask_q == '1 && irq_o == '0));

    assert_ones_keep_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_PEND && wdata_i == '1)
        |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_MSET && wdata_i[SRC_W-1]) |=> mask_q[0]);

    assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & irq_o) == '0);

    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_MCLR && wdata_i[SRC_W-1]) |=> !mask_q[0]);

    assert_prio_zero_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio0 == '0) |-> !irq_o[0]);

    assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_MODE != 0 && !mode_q) |-> (irq_o == '0));
endmodule

bind extpin_irq_ctrl extpin_irq_ctrl_chk #(
    .NUM_PINS(NUM_PINS), .SRC_W(SRC_W), .HAS_MODE(HAS_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i[SRC_W-1:0]), .irq_o(irq_o),
    .pend_q(pend_q), .mask_q(mask_q), .prio0(prio_q[31:28]), .mode_q(mode_q)
);

// File: tb/tb_extpin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_extpin_irq_ctrl;
    import extpin_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  irq;
    logic        irq_any;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] MODE_ON = 32'h0080_0000;

    always #2.5 clk = ~clk;

    extpin_irq_ctrl #(.NUM_PINS(8), .SENSE_W(4), .SRC_W(8), .HAS_MODE(1)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a; re = 1'b1;
        @(posedge clk); @(negedge clk);
        re = 1'b0;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", {24'b0, irq}, 32'h0);
        chk("R1 irq_any after reset", {31'b0, irq_any}, 32'h0);
        rd(A_SENSE, v); chk("R1 sense reset", v, 32'h0);
        rd(A_PRIO, v);  chk("R1 prio reset", v, 32'h0);
        rd(A_PEND, v);  chk("R1 pending reset", v, 32'h0);
        rd(A_CTRL, v);  chk("R1 mode reset", v, 32'h0);
        wait_n(1);
        chk("R11 rdata idle zero", rdata, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_CTRL, MODE_ON);
        wr(A_PRIO, 32'hFFFF_FFFF);
        wr(A_MCLR, 32'h0000_00FF);
        chk("R1 nothing pending once enabled", {24'b0, irq}, 32'h0);
        rd(A_CTRL, v); chk("R11 control readback", v, MODE_ON);
        rd(A_MSET, v); chk("R11 mask-set reads zero", v, 32'h0);
        rd(A_MCLR, v); chk("R11 mask-clear reads zero", v, 32'h0);
    endtask

    task automatic t_rise_edge();
        logic [31:0] v;
        wr(A_SENSE, 32'h1000_0000);
        pin[0] = 1'b1;
        wait_n(2); chk("R2 not yet after two edges", {24'b0, irq}, 32'h0);
        wait_n(1); chk("R2 R3 rising edge pin0", {24'b0, irq}, 32'h01);
        rd(A_PEND, v); chk("R5 R11 pending bit7 for pin0", v, 32'h80);
        pin[0] = 1'b0;
        wait_n(4); chk("R4 edge sticky", {24'b0, irq}, 32'h01);
        wr(A_PEND, 32'hFF); chk("R5 ones ignored", {24'b0, irq}, 32'h01);
        wr(A_PEND, 32'h7F); chk("R5 clear pin0", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_level_high();
        wr(A_SENSE, 32'h0300_0000);
        pin[1] = 1'b1;
        wait_n(3); chk("R3 high level pin1", {24'b0, irq}, 32'h02);
        wr(A_PEND, 32'h0); chk("R4 level re-sets", {24'b0, irq}, 32'h02);
        pin[1] = 1'b0;
        wait_n(3);
        wr(A_PEND, 32'h0); chk("R4 clear after release", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_falling();
        logic [31:0] v;
        wr(A_SENSE, 32'h0);
        pin[2] = 1'b1;
        wait_n(4); chk("R3 falling ignores rise", {24'b0, irq}, 32'h0);
        pin[2] = 1'b0;
        wait_n(3); chk("R3 falling edge pin2", {24'b0, irq}, 32'h04);
        rd(A_PEND, v); chk("R5 pending bit5 for pin2", v, 32'h20);
        wr(A_PEND, 32'hDF); chk("R5 clear pin2", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_both();
        wr(A_SENSE, 32'h0004_0000);
        pin[3] = 1'b1;
        wait_n(3); chk("R3 both: rise pin3", {24'b0, irq}, 32'h08);
        wr(A_PEND, 32'hEF); chk("R5 clear pin3", {24'b0, irq}, 32'h0);
        pin[3] = 1'b0;
        wait_n(3); chk("R3 both: fall pin3", {24'b0, irq}, 32'h08);
        wr(A_PEND, 32'h0); chk("R5 clear all", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_low_level();
        wr(A_SENSE, 32'h0000_2000);
        wait_n(1); chk("R3 low level pin4", {24'b0, irq}, 32'h10);
        pin[4] = 1'b1;
        wait_n(3);
        wr(A_PEND, 32'hF7); chk("R4 low released then cleared", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_bad_code();
        wr(A_SENSE, 32'h0000_0500);
        pin[5] = 1'b1; wait_n(3);
        pin[5] = 1'b0; wait_n(3);
        chk("R3 undefined code detects nothing", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_SENSE, 32'h0000_0030);
        pin[6] = 1'b1;
        wait_n(3); chk("R3 high level pin6", {24'b0, irq}, 32'h40);
        wr(A_MSET, 32'h00); chk("R6 zero mask bits no effect", {24'b0, irq}, 32'h40);
        wr(A_MSET, 32'h02); chk("R6 pin6 masked", {24'b0, irq}, 32'h0);
        chk("R10 any low when all quiet", {31'b0, irq_any}, 32'h0);
        wr(A_MCLR, 32'h00); chk("R7 zero clear bits no effect", {24'b0, irq}, 32'h0);
        wr(A_MCLR, 32'h02); chk("R7 pin6 unmasked", {24'b0, irq}, 32'h40);
        chk("R10 any high", {31'b0, irq_any}, 32'h1);
        wr(A_PRIO, 32'hFFFF_FF0F); chk("R8 zero priority blocks", {24'b0, irq}, 32'h0);
        rd(A_PRIO, v); chk("R11 prio readback", v, 32'hFFFF_FF0F);
        wr(A_PRIO, 32'hFFFF_FFFF); chk("R8 nonzero priority passes", {24'b0, irq}, 32'h40);
        wr(A_CTRL, 32'h0); chk("R9 mode off gates", {24'b0, irq}, 32'h0);
        wr(A_CTRL, MODE_ON); chk("R9 mode on passes", {24'b0, irq}, 32'h40);
        pin[6] = 1'b0;
        wait_n(3);
        wr(A_PEND, 32'h0); chk("R5 clear pin6", {24'b0, irq}, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(A_SENSE, 32'h0000_0001);
        pin[7] = 1'b1;
        wait_n(2);
        wr(A_PEND, 32'h0); chk("R12 detect beats clear", {24'b0, irq}, 32'h80);
        wr(A_PEND, 32'hFE); chk("R5 clear pin7", {24'b0, irq}, 32'h0);
        rd(A_PEND, v); chk("R11 pending empty", v, 32'h0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_enable();
        t_rise_edge();
        t_level_high();
        t_falling();
        t_both();
        t_low_level();
        t_bad_code();
        t_mask();
        t_race();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule